// File: doc/BRIEF.md
# Shared-Adder Small ALU

This block is a purely combinational arithmetic logic unit for narrow operands. It takes two 4-bit operands and a 3-bit operation code and drives a 5-bit result. The top result bit holds the carry out of the arithmetic operations. It has no clock, no storage and no status outputs, and it treats the operands as unsigned.

All four arithmetic operations share one ripple-carry adder built from full-adder cells. The first adder input is always operand A. A four-way selector picks the second adder input from B, A, zero or one, using the two low code bits. The carry-in is the middle code bit. A separate bitwise logic path runs in parallel, and the high code bit chooses between the adder result and the logic result.

Top module: `alu_shared_adder`

## Requirements
- R1: Code 3'b000 gives Y = A + B as a 5-bit unsigned sum, with the carry out in Y[4].
- R2: Code 3'b001 gives Y = 2*A as a 5-bit value, with A[3] shifted into Y[4].
- R3: Code 3'b010 gives Y = A + 1 as a 5-bit value, so A = 15 gives 16.
- R4: Code 3'b011 gives Y = A + 2 as a 5-bit value, so A = 14 gives 16 and A = 15 gives 17.
- R5: Code 3'b100 gives Y[3:0] = bitwise NOT of A and Y[4] = 0.
- R6: Code 3'b101 gives Y[3:0] = A AND B and Y[4] = 0.
- R7: Code 3'b110 gives Y[3:0] = A OR B and Y[4] = 0.
- R8: Code 3'b111 gives Y[3:0] = A XOR B and Y[4] = 0.
- R9: Y depends only on the present inputs. The same inputs give the same Y whatever was applied before, and no clock is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 4 | Operand A, always the first adder input |
| b_in | input | 4 | Operand B |
| op_sel | input | 3 | Operation code; bit 2 picks logic over arithmetic |
| y_out | output | 5 | Result; bit 4 is the carry for arithmetic codes and 0 for logic codes |

## Verification
The bench sweeps every operand pair under all eight codes and compares each result against 5-bit arithmetic computed in the bench.

Carry corners get special attention:
- A wrong carry-in would put the increments off by one.
- A selector that swaps its constant inputs would give A+1 where A+2 is wanted, or the reverse.
- A dropped carry out would wrap 15+15 or 15+2 into four bits.

For the logic codes, any leak of the adder carry into bit 4 shows up directly, and so does a NOT that inverts all five bits. A repeat of earlier inputs after unrelated traffic shows up any hidden state.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OPND_W = 4;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD  = 3'b000,
        OP_DBL  = 3'b001,
        OP_INC1 = 3'b010,
        OP_INC2 = 3'b011,
        OP_NOTA = 3'b100,
        OP_AND  = 3'b101,
        OP_OR   = 3'b110,
        OP_XOR  = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        BSRC_B    = 2'b00,
        BSRC_A    = 2'b01,
        BSRC_ZERO = 2'b10,
        BSRC_ONE  = 2'b11
    } bsrc_e;

    function automatic bsrc_e bsrc_of(input logic [CODE_W-1:0] code);
        return bsrc_e'(code[1:0]);
    endfunction

    function automatic logic is_logic_op(input logic [CODE_W-1:0] code);
        return code[CODE_W-1];
    endfunction

    function automatic logic carry_in_of(input logic [CODE_W-1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = x ^ y ^ ci;
    assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
    parameter int W = alu_pkg::OPND_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] carry;
    assign carry[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        fa_cell u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (carry[i]),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    assign co = carry[W];

    // The cell chain must agree with whole-word arithmetic (R1, R3, R4)
    always_comb begin
        assert_chain_sum_R1: assert ({co, sum} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci}))
            else $error("ripple chain disagrees with word sum");
    end
endmodule

// File: rtl/operand_select.sv
module operand_select #(
    parameter int W = alu_pkg::OPND_W
) (
    input  alu_pkg::bsrc_e sel,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y_opnd
);
    import alu_pkg::*;

    always_comb begin
        case (sel)
            BSRC_B:    y_opnd = b;
            BSRC_A:    y_opnd = a;
            BSRC_ZERO: y_opnd = '0;
            default:   y_opnd = {{(W-1){1'b0}}, 1'b1};
        endcase
    end

    // Constant sources never place more than one bit, and only bit 0 (R3, R4)
    always_comb begin
        if (sel == BSRC_ZERO || sel == BSRC_ONE) begin
            assert_const_operand_R4: assert ($countones(y_opnd) <= 1 && y_opnd[W-1:1] == '0)
                else $error("constant operand has stray bits");
        end
    end
endmodule

// File: rtl/logic_unit.sv
module logic_unit #(
    parameter int W = alu_pkg::OPND_W
) (
    input  logic [1:0]   fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (fn)
            2'b00:   res = ~a;
            2'b01:   res = a & b;
            2'b10:   res = a | b;
            default: res = a ^ b;
        endcase
    end

    // XOR equals OR with the common bits removed (R8)
    always_comb begin
        if (fn == 2'b11) begin
            assert_xor_identity_R8: assert (res == ((a | b) & ~(a & b)))
                else $error("xor result inconsistent");
        end
        if (fn == 2'b00) begin
            assert_not_disjoint_R5: assert ((res & a) == '0 && (res | a) == '1)
                else $error("not result inconsistent");
        end
    end
endmodule

// File: rtl/alu_shared_adder.sv
module alu_shared_adder #(
    parameter int W = alu_pkg::OPND_W
) (
    input  logic [W-1:0]               a_in,
    input  logic [W-1:0]               b_in,
    input  logic [alu_pkg::CODE_W-1:0] op_sel,
    output logic [W:0]                 y_out
);
    import alu_pkg::*;

    logic [W-1:0] add_rhs;
    logic [W-1:0] add_sum;
    logic         add_co;
    logic [W-1:0] lu_res;
    alu_op_e      op;

    assign op = alu_op_e'(op_sel);

    operand_select #(.W(W)) u_sel (
        .sel    (bsrc_of(op_sel)),
        .a      (a_in),
        .b      (b_in),
        .y_opnd (add_rhs)
    );

    ripple_adder #(.W(W)) u_add (
        .x   (a_in),
        .y   (add_rhs),
        .ci  (carry_in_of(op_sel)),
        .sum (add_sum),
        .co  (add_co)
    );

    logic_unit #(.W(W)) u_lu (
        .fn  (op_sel[1:0]),
        .a   (a_in),
        .b   (b_in),
        .res (lu_res)
    );

    assign y_out = is_logic_op(op_sel) ? {1'b0, lu_res} : {add_co, add_sum};

    always_comb begin
        if (is_logic_op(op_sel)) begin
            assert_logic_top_zero_R6: assert (y_out[W] == 1'b0)
                else $error("logic result has carry bit set");
        end
        if (op == OP_DBL) begin
            assert_double_shift_R2: assert (y_out == {a_in, 1'b0})
                else $error("doubling wrong");
        end
        if (op == OP_INC1) begin
            assert_inc_one_R3: assert (y_out == ({1'b0, a_in} + 1'b1))
                else $error("increment by one wrong");
        end
        if (op == OP_INC2) begin
            assert_inc_two_R4: assert (y_out == ({1'b0, a_in} + 2'd2))
                else $error("increment by two wrong");
        end
    end
endmodule

// File: tb/alu_shared_adder_test.sv
module alu_shared_adder_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic [2:0] op_sel = '0;
    logic [4:0] y_out;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_shared_adder uut (
        .a_in   (a_in),
        .b_in   (b_in),
        .op_sel (op_sel),
        .y_out  (y_out)
    );

    function automatic logic [4:0] model(input logic [2:0] c, input logic [3:0] a, input logic [3:0] b);
        logic [4:0] ea = {1'b0, a};
        logic [4:0] eb = {1'b0, b};
        case (c)
            3'd0: return ea + eb;
            3'd1: return ea * 5'd2;
            3'd2: return ea + 5'd1;
            3'd3: return ea + 5'd2;
            3'd4: return {1'b0, ~a};
            3'd5: return ea & eb;
            3'd6: return ea | eb;
            default: return ea ^ eb;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%0d b=%0d actual=%0d expected=%0d",
                     req, op_sel, a_in, b_in, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] c, input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        op_sel = c;
        a_in   = a;
        b_in   = b;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        logic [4:0] first;
        // idle state: all-zero inputs give zero
        apply(3'd0, 4'd0, 4'd0);
        check("R1", y_out, 5'd0);

        // named carry corners
        apply(3'd0, 4'd15, 4'd15); check("R1", y_out, 5'd30);
        apply(3'd1, 4'd8,  4'd0);  check("R2", y_out, 5'd16);
        apply(3'd2, 4'd15, 4'd0);  check("R3", y_out, 5'd16);
        apply(3'd3, 4'd14, 4'd0);  check("R4", y_out, 5'd16);
        apply(3'd3, 4'd15, 4'd0);  check("R4", y_out, 5'd17);
        apply(3'd4, 4'd0,  4'd0);  check("R5", y_out, 5'd15);
        apply(3'd5, 4'd12, 4'd10); check("R6", y_out, 5'd8);
        apply(3'd6, 4'd12, 4'd10); check("R7", y_out, 5'd14);
        apply(3'd7, 4'd15, 4'd15); check("R8", y_out, 5'd0);

        // exhaustive sweep
        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    apply(c[2:0], a[3:0], b[3:0]);
                    check(tag_of(c[2:0]), y_out, model(c[2:0], a[3:0], b[3:0]));
                end
            end
        end

        // R9: no history, same inputs give the same result
        apply(3'd0, 4'd9, 4'd7);
        first = y_out;
        apply(3'd3, 4'd15, 4'd15);
        apply(3'd7, 4'd5, 4'd10);
        apply(3'd0, 4'd9, 4'd7);
        check("R9", y_out, first);
        check("R9", y_out, 5'd16);
        // R9: change settles with no clock edge in between
        op_sel = 3'd6;
        #1;
        check("R9", y_out, 5'd15);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R9 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule